// File: doc/BRIEF.md
# Touch ADC Conversion Sequencer

This block decides when a touch-panel and housekeeping ADC may run a conversion set, holds a busy flag for a fixed conversion time, and then marks the channels of that set as holding fresh data in a data-ready bitmap. Software programs a scan mode, a resolution code and a run/stop flag through a control write port. Results are read one channel at a time, and each read clears that channel's ready bit. The analog front end is not modelled: each channel's 16-bit sample is a fixed input, and the read returns that sample truncated to the resolution in force when the conversion began.

Scan modes fall into three groups. Pressure-dependent modes start only while the pen is down. One-shot modes stop the converter once data is waiting. Free-running modes restart whenever the bitmap has been drained. Two active-low interrupt outputs are provided. The first reports any pending data. The second is a pen interrupt whose meaning can be selected: raw pressure, data pending, or pressure with nothing pending. The pen interrupt is held inactive while the converter is stopped.

Top module: `touch_conv_seq`

## Requirements
- R1: After reset the converter is stopped and idle, the ready bitmap is zero, both interrupt outputs are high (inactive), and the latched mode and resolution are zero.
- R2: A control write loads mode and resolution and sets the run flag to the inverse of the stop bit. A write with stop set while busy aborts the conversion: busy drops on the next cycle and no ready bit is set.
- R3: A conversion starts only when the converter is running, not busy, and the ready bitmap is zero. Modes 1 to 5 also need the pen down. Modes 0, 13, 14 and 15 never start. Modes 6 to 12 need no pen.
- R4: Busy lasts exactly CONV_CYCLES cycles. It then ORs a mode mask into the bitmap: 1→0x600, 2→0x780, 3→0x400, 4→0x200, 5→0x180, 6→0x040, 7→0x030, 8 and 9→0x010, 10→0x004, 11→0x070, 12→0x002.
- R5: The one-shot modes are 3, 4, 5, 6, 7, 8, 10 and 12. In these modes the run flag clears once the bitmap is nonzero. For modes 3 to 5 this happens only while the pen is down. Free-running modes keep the run flag.
- R6: A read of channel c (0 to 9) clears bitmap bit 10−c and returns the channel sample shifted right by 16 minus the bit count. The bit count comes from the resolution latched at conversion start: code 0→12, 1→8, 2→10, 3→12. A read of channel 10 to 15 returns 0xFFFF and clears nothing.
- R7: The pen interrupt is active-low. Its source is selected by the pen function input: 0 is pen pressure, 1 is any ready bit set, and 2 or 3 is pressure with no ready bit set. It is forced high while the converter is stopped.
- R8: The data interrupt is low exactly while any bitmap bit is set.
- R9: The status word carries pen pressure at bit 15, not-busy at bit 14, the latched mode at bits 13:10 and the latched resolution at bits 9:8. Bits 7:0 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_stop_i | input | 1 | Stop bit of the control write |
| ctrl_mode_i | input | 4 | Scan mode of the control write |
| ctrl_res_i | input | 2 | Resolution code of the control write |
| pen_func_i | input | 2 | Pen interrupt source select |
| pen_down_i | input | 1 | Pen pressure present |
| samples_i | input | 160 | Ten 16-bit channel samples, channel c at bits 16c+15:16c |
| rd_i | input | 1 | Result read strobe |
| rd_ch_i | input | 4 | Channel index of the read |
| rd_data_o | output | 16 | Truncated result of the last read |
| busy_o | output | 1 | Conversion in progress |
| enabled_o | output | 1 | Converter run flag |
| dav_o | output | 11 | Data-ready bitmap |
| status_o | output | 16 | Status word |
| pen_irq_n_o | output | 1 | Pen interrupt, active low |
| dav_irq_n_o | output | 1 | Data-ready interrupt, active low |

## Verification
The assertions check several rules on every cycle. Busy may rise only out of an empty bitmap with the run flag set. Mode 0 never leaves idle. A ready bit may drop only after a read. A stop write always leaves the block idle and stopped. The pen interrupt is inactive whenever the converter is stopped.

Some behaviour shows only in the bench's scenarios, which compare against a behavioural model on every clock. These cover:
- the exact mask each mode sets;
- the conversion length;
- the one-shot shutdown;
- a resolution change during a conversion, which takes effect only on the next conversion;
- the three pen interrupt meanings;
- out-of-range reads.

// File: rtl/tcs_pkg.sv
// Shared constants and mode-decoding functions for the touch conversion sequencer.
// Assumes 4-bit mode codes and a data-ready bitmap whose bit 10 belongs to channel 0.
package tcs_pkg;
    localparam int SMP_W  = 16;
    localparam int NCH    = 10;
    localparam int DAV_W  = 11;
    localparam int MODE_W = 4;
    localparam int RES_W  = 2;
    localparam int CH_W   = 4;

    typedef enum logic [MODE_W-1:0] {
        M_IDLE = 4'd0,  M_XY  = 4'd1,  M_XYZ = 4'd2,  M_X    = 4'd3,
        M_Y    = 4'd4,  M_Z   = 4'd5,  M_B1  = 4'd6,  M_B2   = 4'd7,
        M_AUX  = 4'd8,  M_AXS = 4'd9,  M_T1  = 4'd10, M_PORT = 4'd11,
        M_T2   = 4'd12, M_DA  = 4'd13, M_DB  = 4'd14, M_DC   = 4'd15
    } scan_mode_e;

    // Ready bits produced when a conversion set of the given mode completes.
    function automatic logic [DAV_W-1:0] set_mask(input logic [MODE_W-1:0] m);
        case (scan_mode_e'(m))
            M_XY:          set_mask = 11'h600;
            M_XYZ:         set_mask = 11'h780;
            M_X:           set_mask = 11'h400;
            M_Y:           set_mask = 11'h200;
            M_Z:           set_mask = 11'h180;
            M_B1:          set_mask = 11'h040;
            M_B2:          set_mask = 11'h030;
            M_AUX, M_AXS:  set_mask = 11'h010;
            M_T1:          set_mask = 11'h004;
            M_PORT:        set_mask = 11'h070;
            M_T2:          set_mask = 11'h002;
            default:       set_mask = '0;
        endcase
    endfunction

    // Modes that require pen pressure before a conversion may start.
    function automatic logic needs_pen(input logic [MODE_W-1:0] m);
        needs_pen = (m >= 4'd1) && (m <= 4'd5);
    endfunction

    // Modes that may ever start a conversion.
    function automatic logic can_run(input logic [MODE_W-1:0] m);
        can_run = (m != 4'd0) && (m <= 4'd12);
    endfunction

    // Modes that stop the converter once data is waiting.
    function automatic logic one_shot(input logic [MODE_W-1:0] m);
        one_shot = ((m >= 4'd3) && (m <= 4'd8)) || (m == 4'd10) || (m == 4'd12);
    endfunction

    // Right-shift that truncates a 16-bit sample to the coded resolution.
    function automatic logic [4:0] res_shift(input logic [RES_W-1:0] r);
        case (r)
            2'd1:    res_shift = 5'd8;
            2'd2:    res_shift = 5'd6;
            default: res_shift = 5'd4;
        endcase
    endfunction
endpackage

// File: rtl/tcs_sched.sv
// Control latch and start/stop decision for the conversion sequencer.
// Assumes busy and the bitmap summary come from registers, so start is glitch-free per cycle.
module tcs_sched
    import tcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              stop_i,
    input  logic [MODE_W-1:0] wmode_i,
    input  logic [RES_W-1:0]  wres_i,
    input  logic              pen_i,
    input  logic              busy_i,
    input  logic              dav_any_i,
    output logic [MODE_W-1:0] mode_o,
    output logic [RES_W-1:0]  res_o,
    output logic              en_o,
    output logic              start_o,
    output logic              abort_o
);
    logic pen_ok;
    logic kill;

    // Pen qualification and start/shutdown decisions from current state.
    always_comb begin
        pen_ok  = !needs_pen(mode_o) || pen_i;
        start_o = can_run(mode_o) && pen_ok && en_o && !busy_i && !dav_any_i;
        kill    = one_shot(mode_o) && pen_ok && dav_any_i;
        abort_o = wr_i && stop_i;
    end

    // Control register: writes win over the one-shot shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= '0;
            res_o  <= '0;
            en_o   <= 1'b0;
        end else if (wr_i) begin
            mode_o <= wmode_i;
            res_o  <= wres_i;
            en_o   <= !stop_i;
        end else if (kill) begin
            en_o   <= 1'b0;
        end
    end
endmodule

// File: rtl/tcs_timer.sv
// Busy timer: holds busy for CYC cycles after a start and pulses done on the last one.
// Assumes abort has priority over both start and completion.
module tcs_timer #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYC - 1);

    logic [CNT_W-1:0] cnt;

    // Completion is the final busy cycle unless an abort lands on it.
    always_comb done_o = busy_o && (cnt == '0) && !abort_i;

    // Down-counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (abort_i) begin
            busy_o <= 1'b0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            cnt    <= LOAD;
        end else if (busy_o) begin
            if (cnt == '0) busy_o <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/tcs_result.sv
// Data-ready bitmap and result readout with per-conversion resolution latch.
// Assumes channel c owns bitmap bit DAV_W-1-c; bit 0 is never set.
module tcs_result
    import tcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [RES_W-1:0]  res_i,
    input  logic              done_i,
    input  logic              rd_i,
    input  logic [CH_W-1:0]   rd_ch_i,
    input  logic [NCH*SMP_W-1:0] samples_i,
    output logic [DAV_W-1:0]  dav_o,
    output logic [SMP_W-1:0]  rd_data_o
);
    logic [MODE_W-1:0] func_q;
    logic [RES_W-1:0]  res_q;
    logic [DAV_W-1:0]  clr;
    logic [SMP_W-1:0]  sel;
    logic              in_range;

    // Decode the read into a clear mask and a selected sample.
    always_comb begin
        in_range = (int'(rd_ch_i) < NCH);
        clr      = '0;
        sel      = '1;
        for (int c = 0; c < NCH; c++) begin
            if (int'(rd_ch_i) == c) begin
                clr[DAV_W-1-c] = rd_i;
                sel            = samples_i[c*SMP_W +: SMP_W];
            end
        end
    end

    // Latch function and resolution when a conversion begins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_q <= '0;
            res_q  <= '0;
        end else if (start_i) begin
            func_q <= mode_i;
            res_q  <= res_i;
        end
    end

    // Bitmap: reads clear first, completion sets after.
    always_ff @(posedge clk) begin
        if (!rst_n) dav_o <= '0;
        else        dav_o <= (dav_o & ~clr) | (done_i ? set_mask(func_q) : '0);
    end

    // Read data register: truncated sample or all-ones for an absent channel.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data_o <= '0;
        else if (rd_i)   rd_data_o <= in_range ? (sel >> res_shift(res_q)) : '1;
    end
endmodule

// File: rtl/touch_conv_seq.sv
// Top of the touch ADC conversion sequencer: schedules conversions, times them,
// keeps the data-ready bitmap and drives two active-low interrupts.
// Assumes samples are static stand-ins for the analog front end.
module touch_conv_seq
    import tcs_pkg::*;
#(
    parameter int CLK_HZ      = 1024000,
    parameter int CONV_CYCLES = CLK_HZ / 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_wr_i,
    input  logic                  ctrl_stop_i,
    input  logic [MODE_W-1:0]     ctrl_mode_i,
    input  logic [RES_W-1:0]      ctrl_res_i,
    input  logic [1:0]            pen_func_i,
    input  logic                  pen_down_i,
    input  logic [NCH*SMP_W-1:0]  samples_i,
    input  logic                  rd_i,
    input  logic [CH_W-1:0]       rd_ch_i,
    output logic [SMP_W-1:0]      rd_data_o,
    output logic                  busy_o,
    output logic                  enabled_o,
    output logic [DAV_W-1:0]      dav_o,
    output logic [15:0]           status_o,
    output logic                  pen_irq_n_o,
    output logic                  dav_irq_n_o
);
    localparam int CYC = (CONV_CYCLES < 1) ? 1 : CONV_CYCLES;

    logic [MODE_W-1:0] mode_q;
    logic [RES_W-1:0]  res_q;
    logic start, abort, done, dav_any, pen_src;

    tcs_sched u_sched (
        .clk(clk), .rst_n(rst_n), .wr_i(ctrl_wr_i), .stop_i(ctrl_stop_i),
        .wmode_i(ctrl_mode_i), .wres_i(ctrl_res_i), .pen_i(pen_down_i),
        .busy_i(busy_o), .dav_any_i(dav_any), .mode_o(mode_q), .res_o(res_q),
        .en_o(enabled_o), .start_o(start), .abort_o(abort)
    );

    tcs_timer #(.CYC(CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .busy_o(busy_o), .done_o(done)
    );

    tcs_result u_result (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode_q),
        .res_i(res_q), .done_i(done), .rd_i(rd_i), .rd_ch_i(rd_ch_i),
        .samples_i(samples_i), .dav_o(dav_o), .rd_data_o(rd_data_o)
    );

    // Interrupt source selection and status assembly.
    always_comb begin
        dav_any = |dav_o;
        case (pen_func_i)
            2'd0:    pen_src = pen_down_i;
            2'd1:    pen_src = dav_any;
            default: pen_src = pen_down_i && !dav_any;
        endcase
        pen_irq_n_o = !(enabled_o && pen_src);
        dav_irq_n_o = !dav_any;
        status_o    = {pen_down_i, !busy_o, mode_q, res_q, 8'h00};
    end
endmodule

// File: rtl/touch_conv_seq_chk.sv
// Property checker for touch_conv_seq, attached by bind.
module touch_conv_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ctrl_wr_i,
    input logic        ctrl_stop_i,
    input logic        rd_i,
    input logic        busy_o,
    input logic        enabled_o,
    input logic [10:0] dav_o,
    input logic [15:0] status_o,
    input logic        pen_irq_n_o
);
    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !$past(busy_o)) |-> ($past(dav_o) == 11'd0 && $past(enabled_o)));

    // R3
    no_scan_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[13:10] == 4'd0 && !busy_o) |=> !busy_o);

    // R6
    dav_clear_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(dav_o) & ~dav_o)) |-> $past(rd_i));

    // R2
    stop_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && ctrl_stop_i) |=> (!busy_o && !enabled_o));

    // R7
    pen_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled_o |-> pen_irq_n_o);
endmodule

bind touch_conv_seq touch_conv_seq_chk i_chk (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr_i), .ctrl_stop_i(ctrl_stop_i),
    .rd_i(rd_i), .busy_o(busy_o), .enabled_o(enabled_o), .dav_o(dav_o),
    .status_o(status_o), .pen_irq_n_o(pen_irq_n_o)
);

// File: tb/test_touch_conv_seq.sv
module test_touch_conv_seq;
    localparam int CLK_PERIOD = 10;
    localparam int HZ   = 16384;
    localparam int CONV = HZ / 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0, stop = 1'b0, pen = 1'b0, rd = 1'b0;
    logic [3:0] wmode = '0, rch = '0;
    logic [1:0] wres = '0, pfunc = 2'd2;
    logic [159:0] samples;
    logic [15:0] rd_data, status;
    logic busy, en, pen_irq_n, dav_irq_n;
    logic [10:0] dav;

    int checks = 0, fails = 0, cyc = 0;

    // behavioural reference state
    int m_mode, m_resn, m_func, m_rlat, m_cnt, m_dav, m_rd;
    bit m_en, m_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    touch_conv_seq #(.CLK_HZ(HZ)) i_touch_conv_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(wr), .ctrl_stop_i(stop),
        .ctrl_mode_i(wmode), .ctrl_res_i(wres), .pen_func_i(pfunc),
        .pen_down_i(pen), .samples_i(samples), .rd_i(rd), .rd_ch_i(rch),
        .rd_data_o(rd_data), .busy_o(busy), .enabled_o(en), .dav_o(dav),
        .status_o(status), .pen_irq_n_o(pen_irq_n), .dav_irq_n_o(dav_irq_n)
    );

    function automatic int samp(int c);
        return (16'h1357 + c * 16'h1111) & 16'hFFFF;
    endfunction

    function automatic int mask_of(int m);
        case (m)
            1: return 'h600;  2: return 'h780;  3: return 'h400;  4: return 'h200;
            5: return 'h180;  6: return 'h040;  7: return 'h030;  8: return 'h010;
            9: return 'h010; 10: return 'h004; 11: return 'h070; 12: return 'h002;
            default: return 0;
        endcase
    endfunction

    function automatic int bits_of(int r);
        if (r == 1) return 8;
        if (r == 2) return 10;
        return 12;
    endfunction

    function automatic bit pen_rule(int m, bit p);
        if (m >= 1 && m <= 5) return p;
        return (m >= 6 && m <= 12);
    endfunction

    function automatic bit single(int m);
        return (m >= 3 && m <= 8) || m == 10 || m == 12;
    endfunction

    // Reference model advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_resn = 0; m_func = 0; m_rlat = 0; m_cnt = 0;
            m_dav = 0; m_rd = 0; m_en = 0; m_busy = 0;
        end else begin
            int clr, setm;
            bit go, kill, ab;
            clr = (rd && rch < 10) ? (1 << (10 - rch)) : 0;
            ab  = wr && stop;
            setm = (m_busy && m_cnt == 0 && !ab) ? mask_of(m_func) : 0;
            go  = pen_rule(m_mode, pen) && m_en && !m_busy && m_dav == 0;
            kill = single(m_mode) && m_dav != 0 && (pen || !(m_mode >= 3 && m_mode <= 5));
            if (rd) m_rd = (rch < 10) ? (samp(rch) >> (16 - bits_of(m_rlat))) : 'hFFFF;
            m_dav = (m_dav & ~clr) | setm;
            if (ab) m_busy = 0;
            else if (go) begin m_busy = 1; m_cnt = CONV - 1; m_func = m_mode; m_rlat = m_resn; end
            else if (m_busy) begin if (m_cnt == 0) m_busy = 0; else m_cnt--; end
            if (wr) begin m_mode = wmode; m_resn = wres; m_en = !stop; end
            else if (kill) m_en = 0;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            bit src;
            int st;
            case (pfunc)
                2'd0: src = pen;
                2'd1: src = (m_dav != 0);
                default: src = pen && (m_dav == 0);
            endcase
            st = (int'(pen) << 15) | (int'(!m_busy) << 14) | (m_mode << 10) | (m_resn << 8);
            chk("R4 busy", busy, m_busy);
            chk("R4 dav", dav, m_dav);
            chk("R5 enabled", en, m_en);
            chk("R6 rd_data", rd_data, m_rd);
            chk("R7 pen_irq_n", pen_irq_n, !(m_en && src));
            chk("R8 dav_irq_n", dav_irq_n, m_dav == 0);
            chk("R9 status", status, st);
        end
        if (cyc > 100000) begin
            fails++;
            $display("FAIL R1 watchdog actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic cfg(bit s, int m, int r);
        @(negedge clk); wr = 1; stop = s; wmode = m[3:0]; wres = r[1:0];
        @(negedge clk); wr = 0;
    endtask

    task automatic rdc(int c);
        @(negedge clk); rd = 1; rch = c[3:0];
        @(negedge clk); rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 10; c++) samples[c*16 +: 16] = samp(c)[15:0];
        idle(4); rst_n = 1; @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0); chk("R1 dav", dav, 0); chk("R1 en", en, 0);
        chk("R1 pen_irq_n", pen_irq_n, 1); chk("R1 dav_irq_n", dav_irq_n, 1);
        chk("R1 status", status, 'h4000);

        // R3 XY mode with pen up never starts
        cfg(0, 1, 0); idle(40);
        chk("R3 xy pen up busy", busy, 0); chk("R3 xy pen up dav", dav, 0);
        pen = 1; idle(CONV + 10);
        chk("R4 xy mask", dav, 'h600);
        chk("R7 pressure with data pending", pen_irq_n, 1);
        rdc(0); chk("R6 x 12 bit", rd_data, 'h135); chk("R6 x cleared", dav, 'h200);
        rdc(1); idle(3);
        chk("R3 scan restarts", busy, 1); chk("R7 pressure, none pending", pen_irq_n, 0);
        cfg(0, 1, 1); idle(CONV + 10);
        rdc(0); chk("R6 old resolution kept", rd_data, 'h135);
        rdc(1); idle(CONV + 10);
        rdc(0); chk("R6 8 bit", rd_data, 'h13);
        pen = 0; rdc(1); idle(CONV + 10);
        chk("R3 pen up stops scan", busy, 0);

        // R2 abort
        cfg(0, 10, 0); idle(5); chk("R2 busy before stop", busy, 1);
        cfg(1, 10, 0); idle(CONV + 10);
        chk("R2 aborted busy", busy, 0); chk("R2 aborted dav", dav, 0); chk("R2 stopped", en, 0);

        // R5 one-shot BAT1
        cfg(0, 6, 2); idle(CONV + 10);
        chk("R4 bat1 mask", dav, 'h040); chk("R5 one-shot stop", en, 0);
        chk("R7 masked when stopped", pen_irq_n, 1);
        rdc(4); chk("R6 10 bit", rd_data, 'h15E); idle(CONV + 5);
        chk("R5 no rerun", busy, 0);

        // R5 X mode without pen: runs nothing, stays enabled
        cfg(0, 3, 0); idle(CONV + 10);
        chk("R3 x pen up", busy, 0); chk("R5 x pen up keeps run", en, 1);
        cfg(0, 0, 0); idle(CONV + 5); chk("R3 mode 0 idle", busy, 0);
        cfg(0, 13, 0); idle(CONV + 5); chk("R3 mode 13 idle", busy, 0);

        // XYZ with alternate pen functions
        pen = 1; cfg(0, 2, 0); idle(CONV + 10);
        chk("R4 xyz mask", dav, 'h780);
        pfunc = 1; @(negedge clk); chk("R7 data source", pen_irq_n, 0);
        chk("R8 data irq", dav_irq_n, 0);
        chk("R9 status word", status, 'hC800);
        rdc(12); chk("R6 out of range data", rd_data, 'hFFFF); chk("R6 out of range dav", dav, 'h780);
        pfunc = 0; @(negedge clk); chk("R7 pressure source", pen_irq_n, 0);
        pen = 0; @(negedge clk); chk("R7 pressure released", pen_irq_n, 1);
        rdc(0); rdc(1); rdc(2); rdc(3); idle(CONV + 5);
        chk("R8 drained", dav_irq_n, 1); chk("R3 xyz needs pen", busy, 0);

        // Port scan free-running
        cfg(0, 11, 0); idle(CONV + 10);
        chk("R4 port mask", dav, 'h070); chk("R5 scan keeps run", en, 1);
        rdc(4); rdc(5); rdc(6); idle(3);
        chk("R3 port rescan", busy, 1);
        cfg(1, 11, 0); idle(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule